// File: doc/BRIEF.md
# Serial Transmit Framer with Stick Parity

This block turns bytes into asynchronous serial frames on a single output line. Each frame carries one start bit (logic 0), then five to eight data bits, least significant bit first. An optional parity bit follows, then one or two stop bits (logic 1). A line control register selects the frame shape and the parity mode. The parity modes are none, odd, even, a fixed 1 (mark) and a fixed 0 (space). Another bit of the same register holds the line low as a break condition.

The bit rate comes from a 16-bit divisor. Every bit lasts divisor × 16 clock cycles, and a divisor of zero acts as one. Software reaches the line control register and the two divisor bytes through a small write/read port. Bytes to send arrive on a valid/ready handshake. The frame settings and the divisor are captured when a byte is accepted, so a frame is never reshaped halfway through.

Top module: `uart_stick_tx`

## Requirements
- R1: After reset, txd is 1, tx_ready is 1, the line control register (offset 3) reads 0x00 and both divisor bytes read 0x00.
- R2: A frame is a 0 start bit, then N data bits LSB first, where N = 5 + ctl[1:0] (00 = 5 bits, 11 = 8 bits), then the stop bits at 1.
- R3: ctl[2] = 0 gives one stop bit; ctl[2] = 1 gives two stop bits.
- R4: With ctl[3] = 0, no parity bit is sent, whatever ctl[4] and ctl[5] hold.
- R5: With ctl[3] = 1 and ctl[5] = 0, ctl[4] = 0 gives odd parity and ctl[4] = 1 gives even parity, taken over the N data bits only.
- R6: With ctl[3] = 1 and ctl[5] = 1, the parity bit is always 1 when ctl[4] = 0 and always 0 when ctl[4] = 1.
- R7: Every bit of a frame lasts max(D,1) × 16 clock cycles. D is the 16-bit divisor: the low byte is at offset 0 and the high byte at offset 1, both reachable only while ctl[7] = 1. D is captured when the byte is accepted.
- R8: While ctl[7] = 1, tx_ready is 0 and no byte is accepted. While ctl[7] = 0, writes to offsets 0 and 1 leave the divisor unchanged.
- R9: While ctl[6] = 1, txd is 0 from the cycle after the write. A frame in flight keeps its timing underneath, and clearing the bit returns txd to the frame's current level.
- R10: A byte is accepted on a clock edge where tx_valid and tx_ready are both 1, and its start bit shows on txd from that edge. tx_ready is 1 only when no frame is in progress. Back-to-back frames follow each other with one idle cycle at 1.
- R11: A write to offset 3 sets the line control register, and the new value reads back from offset 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register offset: 0 divisor low, 1 divisor high, 3 line control |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for bus_addr (combinational) |
| tx_valid | input | 1 | Byte offered for sending |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Framer is idle and can take a byte |
| txd | output | 1 | Serial output line, idles at 1 |

## Verification
A register write takes effect at the clock edge that samples it. The break override and tx_ready therefore change one cycle after the write, while bus_rdata follows bus_addr within the same cycle. The start bit of an accepted byte appears from the accepting edge. The frame then changes level exactly every max(D,1) × 16 cycles, and tx_ready returns one cycle after the last stop bit ends. The bench model turns each accepted byte into a queue of per-cycle line levels, advances that queue on the same edges as the design, and compares txd and tx_ready at every falling clock edge. Each comparison therefore lands mid-cycle on the exact cycle where a level is due.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef struct packed {
        logic       dlab;
        logic       brk;
        logic       stick;
        logic       even;
        logic       par_en;
        logic       two_stop;
        logic [1:0] wlen;
    } line_ctl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    localparam logic [1:0] OFS_DIV_LO = 2'd0;
    localparam logic [1:0] OFS_DIV_HI = 2'd1;
    localparam logic [1:0] OFS_CTL    = 2'd3;

    function automatic logic [2:0] last_data_idx(input logic [1:0] wlen);
        return 3'd4 + {1'b0, wlen};
    endfunction

    function automatic logic frame_parity(input line_ctl_t c, input logic [7:0] d);
        logic x;
        x = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (3'(i) <= last_data_idx(c.wlen)) x = x ^ d[i];
        end
        if (c.stick) return ~c.even;
        return c.even ? x : ~x;
    endfunction

endpackage

// File: rtl/uart_tx_regs.sv
module uart_tx_regs
    import uart_tx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output line_ctl_t        ctl,
    output logic [DIV_W-1:0] divisor
);
    localparam int HI_W = DIV_W - 8;

    line_ctl_t        ctl_q;
    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            div_q <= '0;
        end else if (we) begin
            if (addr == OFS_CTL) ctl_q <= line_ctl_t'(wdata);
            if (ctl_q.dlab && addr == OFS_DIV_LO) div_q[7:0] <= wdata;
            if (ctl_q.dlab && addr == OFS_DIV_HI) div_q[DIV_W-1:8] <= wdata[HI_W-1:0];
        end
    end

    always_comb begin
        rdata = 8'h00;
        case (addr)
            OFS_CTL:    rdata = 8'(ctl_q);
            OFS_DIV_LO: rdata = ctl_q.dlab ? div_q[7:0] : 8'h00;
            OFS_DIV_HI: rdata = ctl_q.dlab ? 8'(div_q >> 8) : 8'h00;
            default:    rdata = 8'h00;
        endcase
    end

    assign ctl     = ctl_q;
    assign divisor = div_q;

    assert_div_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (we && !ctl_q.dlab && (addr == OFS_DIV_LO || addr == OFS_DIV_HI)) |=> $stable(div_q));

    assert_ctl_write_R11: assert property (@(posedge clk) disable iff (rst)
        (we && addr == OFS_CTL) |=> (8'(ctl_q) == $past(wdata)));

endmodule

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clear,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 4;

    logic [DIV_W-1:0] div_eff;
    logic [CNT_W-1:0] last;
    logic [CNT_W-1:0] cnt;

    assign div_eff = (divisor == '0) ? DIV_W'(1) : divisor;
    assign last    = {div_eff, 4'b0000} - CNT_W'(1);
    assign tick    = run && !clear && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || clear || !run) cnt <= '0;
        else if (cnt == last)     cnt <= '0;
        else                      cnt <= cnt + CNT_W'(1);
    end

    assert_no_early_tick_R7: assert property (@(posedge clk) disable iff (rst)
        clear |=> !tick);

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import uart_tx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  line_ctl_t        ctl,
    input  logic [DIV_W-1:0] divisor,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    input  logic             tick,
    output logic             baud_run,
    output logic             baud_clear,
    output logic [DIV_W-1:0] div_frame,
    output logic             line
);
    tx_state_e        state;
    line_ctl_t        cfg;
    logic [7:0]       shreg;
    logic             par_q;
    logic [2:0]       cnt;
    logic [DIV_W-1:0] div_q;
    logic             line_q;
    logic             accept;

    assign in_ready   = (state == ST_IDLE) && !ctl.dlab;
    assign accept     = in_valid && in_ready;
    assign baud_run   = (state != ST_IDLE);
    assign baud_clear = accept;
    assign div_frame  = div_q;
    assign line       = line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cfg    <= '0;
            shreg  <= '0;
            par_q  <= 1'b0;
            cnt    <= '0;
            div_q  <= '0;
            line_q <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cfg    <= ctl;
                        shreg  <= in_data;
                        par_q  <= frame_parity(ctl, in_data);
                        div_q  <= divisor;
                        cnt    <= '0;
                        line_q <= 1'b0;
                        state  <= ST_START;
                    end
                end
                ST_START: begin
                    if (tick) begin
                        line_q <= shreg[0];
                        shreg  <= shreg >> 1;
                        cnt    <= '0;
                        state  <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (tick) begin
                        if (cnt == last_data_idx(cfg.wlen)) begin
                            cnt <= '0;
                            if (cfg.par_en) begin
                                line_q <= par_q;
                                state  <= ST_PAR;
                            end else begin
                                line_q <= 1'b1;
                                state  <= ST_STOP;
                            end
                        end else begin
                            line_q <= shreg[0];
                            shreg  <= shreg >> 1;
                            cnt    <= cnt + 3'd1;
                        end
                    end
                end
                ST_PAR: begin
                    if (tick) begin
                        line_q <= 1'b1;
                        cnt    <= '0;
                        state  <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (tick) begin
                        if (cnt == {2'b00, cfg.two_stop}) state <= ST_IDLE;
                        else                               cnt   <= cnt + 3'd1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_start_low_R10: assert property (@(posedge clk) disable iff (rst)
        accept |=> (!line_q && state == ST_START));

    assert_idle_high_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> line_q);

    assert_stop_high_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STOP) |-> line_q);

    assert_parity_slot_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PAR) |-> cfg.par_en);

endmodule

// File: rtl/uart_stick_tx.sv
module uart_stick_tx
    import uart_tx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_we,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    output logic       tx_ready,
    output logic       txd
);
    line_ctl_t        ctl;
    logic [DIV_W-1:0] divisor;
    logic [DIV_W-1:0] div_frame;
    logic             tick;
    logic             baud_run;
    logic             baud_clear;
    logic             line;

    uart_tx_regs #(.DIV_W(DIV_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .ctl     (ctl),
        .divisor (divisor)
    );

    uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .run     (baud_run),
        .clear   (baud_clear),
        .divisor (div_frame),
        .tick    (tick)
    );

    uart_tx_framer #(.DIV_W(DIV_W)) u_framer (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .divisor    (divisor),
        .in_valid   (tx_valid),
        .in_data    (tx_data),
        .in_ready   (tx_ready),
        .tick       (tick),
        .baud_run   (baud_run),
        .baud_clear (baud_clear),
        .div_frame  (div_frame),
        .line       (line)
    );

    assign txd = ctl.brk ? 1'b0 : line;

    assert_ready_blocked_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_we) && $past(bus_addr) == OFS_CTL && $past(bus_wdata[7])) |-> !tx_ready);

endmodule

// File: tb/test_uart_stick_tx.sv
module test_uart_stick_tx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_ready;
    logic       txd;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uart_stick_tx i_uart_stick_tx (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .txd(txd)
    );

    // behavioural reference model
    bit         exp_q[$];
    logic [7:0] m_ctl = 8'h00;
    logic [7:0] m_dll = 8'h00;
    logic [7:0] m_dlm = 8'h00;
    bit         m_cur = 1'b1;
    bit         m_popped = 1'b0;
    bit         exp_ready = 1'b1;
    bit         exp_txd = 1'b1;

    task automatic push_frame(input logic [7:0] d);
        int dv;
        int n;
        int wl;
        bit x;
        dv = {m_dlm, m_dll};
        if (dv == 0) dv = 1;
        n  = dv * 16;
        wl = 5 + int'(m_ctl[1:0]);
        x  = 1'b0;
        for (int k = 0; k < n; k++) exp_q.push_back(1'b0);
        for (int b = 0; b < wl; b++) begin
            x = x ^ d[b];
            for (int k = 0; k < n; k++) exp_q.push_back(d[b]);
        end
        if (m_ctl[3]) begin
            bit p;
            if (m_ctl[5]) p = ~m_ctl[4];
            else          p = m_ctl[4] ? x : ~x;
            for (int k = 0; k < n; k++) exp_q.push_back(p);
        end
        for (int s = 0; s < (m_ctl[2] ? 2 : 1); s++)
            for (int k = 0; k < n; k++) exp_q.push_back(1'b1);
    endtask

    always @(posedge clk) begin
        logic [7:0] nctl;
        if (rst) begin
            exp_q.delete();
            m_ctl = 8'h00; m_dll = 8'h00; m_dlm = 8'h00;
            m_cur = 1'b1; m_popped = 1'b0;
        end else begin
            nctl = m_ctl;
            if (tx_valid && exp_ready) push_frame(tx_data);
            if (bus_we) begin
                if (bus_addr == 2'd3) nctl = bus_wdata;
                if (m_ctl[7] && bus_addr == 2'd0) m_dll = bus_wdata;
                if (m_ctl[7] && bus_addr == 2'd1) m_dlm = bus_wdata;
            end
            if (exp_q.size() > 0) begin
                m_cur = exp_q.pop_front();
                m_popped = 1'b1;
            end else begin
                m_cur = 1'b1;
                m_popped = 1'b0;
            end
            m_ctl = nctl;
        end
        exp_ready = !m_popped && !m_ctl[7];
        exp_txd   = m_ctl[6] ? 1'b0 : m_cur;
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (txd !== exp_txd) begin
                errors++;
                $display("FAIL %s txd actual %b expected %b at cycle %0d", cur_req, txd, exp_txd, cycles);
            end
            checks++;
            if (tx_ready !== exp_ready) begin
                errors++;
                $display("FAIL %s tx_ready actual %b expected %b at cycle %0d", cur_req, tx_ready, exp_ready, cycles);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input logic [1:0] a, input logic [7:0] e, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== e) begin
            errors++;
            $display("FAIL %s read offset %0d actual %h expected %h", req, a, bus_rdata, e);
        end
    endtask

    task automatic send(input logic [7:0] d);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_valid = 1'b1; tx_data = d;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!tx_ready || exp_q.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic set_div(input logic [15:0] dv, input logic [7:0] ctl_after);
        wr(2'd3, 8'h80);
        wr(2'd0, dv[7:0]);
        wr(2'd1, dv[15:8]);
        wr(2'd3, ctl_after);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        cur_req = "R1";
        @(negedge clk);
        checks++;
        if (txd !== 1'b1 || tx_ready !== 1'b1) begin
            errors++;
            $display("FAIL R1 txd/ready actual %b%b expected 11", txd, tx_ready);
        end
        rd_check(2'd3, 8'h00, "R1");
        wr(2'd3, 8'h80);
        rd_check(2'd0, 8'h00, "R1");
        rd_check(2'd1, 8'h00, "R1");

        // R7: divisor 0 acts as 1; readback of divisor bytes
        cur_req = "R7";
        wr(2'd3, 8'h03);
        send(8'h96);
        wait_idle();
        set_div(16'd1, 8'h83);
        rd_check(2'd0, 8'h01, "R7");
        rd_check(2'd1, 8'h00, "R7");
        // R11: line control readback
        rd_check(2'd3, 8'h83, "R11");
        wr(2'd3, 8'h03);
        rd_check(2'd3, 8'h03, "R11");

        // R2: word lengths
        cur_req = "R2";
        send(8'hA5); wait_idle();
        wr(2'd3, 8'h00); send(8'h1F); wait_idle();
        wr(2'd3, 8'h01); send(8'h2A); wait_idle();
        wr(2'd3, 8'h02); send(8'h5B); wait_idle();

        // R3: two stop bits; R10: back-to-back frames
        cur_req = "R3";
        wr(2'd3, 8'h07); send(8'hC3); wait_idle();
        cur_req = "R10";
        wr(2'd3, 8'h03);
        send(8'h01); send(8'h80); send(8'hFF); wait_idle();

        // R4: parity disabled although bits 4 and 5 set
        cur_req = "R4";
        wr(2'd3, 8'h33); send(8'h7E); wait_idle();

        // R5: odd and even parity, odd and even weight data
        cur_req = "R5";
        wr(2'd3, 8'h0B); send(8'h07); wait_idle();
        send(8'h03); wait_idle();
        wr(2'd3, 8'h1B); send(8'h07); wait_idle();
        wr(2'd3, 8'h18); send(8'hE3); wait_idle();

        // R6: forced mark and space
        cur_req = "R6";
        wr(2'd3, 8'h2B); send(8'h00); wait_idle();
        wr(2'd3, 8'h3B); send(8'hFF); wait_idle();

        // R7: divisor 3 and a divisor using the high byte
        cur_req = "R7";
        set_div(16'd3, 8'h0F); send(8'h5A); wait_idle();
        set_div(16'h0102, 8'h00); send(8'h15); wait_idle();
        set_div(16'd1, 8'h03);

        // R8: latch selected blocks handshake; writes ignored when not selected
        cur_req = "R8";
        wr(2'd3, 8'h80);
        @(negedge clk);
        checks++;
        if (tx_ready !== 1'b0) begin
            errors++;
            $display("FAIL R8 tx_ready actual %b expected 0", tx_ready);
        end
        tx_valid = 1'b1; tx_data = 8'h33;
        repeat (20) @(negedge clk);
        tx_valid = 1'b0;
        wr(2'd3, 8'h03);
        wr(2'd0, 8'h55);
        wr(2'd1, 8'hAA);
        wr(2'd3, 8'h83);
        rd_check(2'd0, 8'h01, "R8");
        rd_check(2'd1, 8'h00, "R8");
        wr(2'd3, 8'h03);

        // R9: break at idle and in mid-frame
        cur_req = "R9";
        wr(2'd3, 8'h43);
        repeat (10) @(negedge clk);
        wr(2'd3, 8'h03);
        send(8'hF0);
        repeat (40) @(negedge clk);
        wr(2'd3, 8'h43);
        repeat (57) @(negedge clk);
        wr(2'd3, 8'h03);
        wait_idle();

        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule